// File: doc/BRIEF.md
# Non-Volatile Retention Power Sequencer

This block sequences state backup and power gating for a group of independently switched power domains. Each domain has a non-volatile shadow of its flip-flops. Commands arrive over a valid/ready handshake. Each command carries an operation code and a domain bitmap. The sequencer then drives per-domain controls: write pulse, read-back pulse, verify request, power-switch open and isolation clamp. It waits on per-domain acknowledge and verify-result inputs before it moves on.

Backups use a short write pulse whose length is programmed in clock cycles. A verify step checks each write. Domains that fail verification are written again, and only those domains are rewritten, until all of them pass or a programmable retry limit runs out. Compound operations chain the backup, verify, retry and power-down steps into a single command.

The sequencer keeps a per-domain "verified since last write" record. A power-down request for a domain without a valid backup first runs a backup of that domain. Isolation clamps always enclose the time a domain's power switch is open.

Top module: `nvr_power_mgr`

## Requirements
- R1: Operation codes on `cmd_op` are 0 write, 1 verify only, 2 write with verify and retry, 3 power-down, 4 power-up, 5 read-back, 6 write with verify and retry and then power-down, and 7 no operation. `cmd_ready` is high only while the sequencer is idle. `busy` is high from the cycle after a command is accepted until the command completes. `done` pulses for exactly one cycle per command.
- R2: A write step drives `nv_store` for the selected domains for exactly `store_len` cycles, and a length of 0 acts as 1.
- R3: A read-back step drives `nv_restore` for exactly `restore_len` cycles, and a length of 0 acts as 1.
- R4: A verify step keeps `nv_verify` asserted until every selected domain has raised `vfy_valid`. Each domain's `vfy_pass` is sampled in the cycle its `vfy_valid` first appears.
- R5: After a failed verify, only the failing domains are written again. Passing domains get no further write pulse. The loop repeats until all selected domains pass.
- R6: At most `max_retry` rewrites follow the first write. When the limit runs out with domains still failing, `err` is set and stays set until reset, and the failing domains' bits are ORed into `fail_mask`.
- R7: On power-down, a domain's `iso` rises at least one cycle before its `pwr_off` rises. `pwr_off` is never high without `iso`. The command completes only after `off_ack` is high for every domain being powered down. A domain that failed verification during the same command is not powered down.
- R8: On power-up, `pwr_off` is cleared first. The read-back pulse starts only after `pwr_good` is high for all selected domains. `iso` is released for those domains when the pulse ends.
- R9: A power-down command first runs write, verify and retry on the selected domains that have no valid backup. Domains that already hold a verified backup are not written again.
- R10: Operation 6 writes every selected domain, verifies it, retries it as needed and then powers it down, all within one command.
- R11: A plain write (operation 0) marks its domains as not verified. A passing verify (operation 1, 2, 3 or 6) marks them as verified.
- R12: After reset, every output control is low, `cmd_ready` is high, and `err` and `fail_mask` are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| cmd_op | input | 3 | Operation code (see R1) |
| cmd_mask | input | NDOM | Domain bitmap |
| store_len | input | PW | Write pulse length in cycles |
| restore_len | input | PW | Read-back pulse length in cycles |
| max_retry | input | RW | Maximum number of rewrites |
| nv_store | output | NDOM | Per-domain write pulse |
| nv_restore | output | NDOM | Per-domain read-back pulse |
| nv_verify | output | NDOM | Per-domain verify request |
| vfy_valid | input | NDOM | Verify result available |
| vfy_pass | input | NDOM | Verify result is good |
| pwr_off | output | NDOM | Power switch open |
| iso | output | NDOM | Output isolation clamp |
| off_ack | input | NDOM | Domain has powered off |
| pwr_good | input | NDOM | Domain supply is good |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky retry-exhaustion flag |
| fail_mask | output | NDOM | Sticky per-domain failure record |

## Verification
Some rules hold on every cycle and are checked as such. Isolation leads and encloses the open power switch. `busy` rises only after an accepted command. `done` never lasts two cycles. The retry count stays within its limit. A retry bitmap never gains a domain. Other behaviour shows up only across a whole command, so the bench scenarios have to expose it. Examples are the exact pulse widths, how many write pulses each domain receives under injected verify failures, and the hidden backup that a power-down of an unverified domain triggers. The same holds for retry exhaustion leaving failed domains powered, the sticky error, and a read-back that waits for supply-good.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

  typedef enum logic [2:0] {
    OP_STORE       = 3'd0,
    OP_VERIFY      = 3'd1,
    OP_STORE_VFY   = 3'd2,
    OP_SLEEP       = 3'd3,
    OP_WAKE        = 3'd4,
    OP_RESTORE     = 3'd5,
    OP_STORE_SLEEP = 3'd6,
    OP_NOP         = 3'd7
  } nvr_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STORE,
    ST_VFY,
    ST_ISO,
    ST_OFFW,
    ST_PGW,
    ST_RST
  } nvr_state_e;

  // last cycle of a pulse whose length counts from 1; zero behaves as one
  function automatic logic pulse_last(input int unsigned cnt, input int unsigned len);
    int unsigned eff;
    eff = (len == 0) ? 1 : len;
    return (cnt + 1) >= eff;
  endfunction

  // another rewrite is permitted while fewer than limit have been spent
  function automatic logic retry_allowed(input int unsigned used, input int unsigned limit);
    return used < limit;
  endfunction

endpackage

// File: rtl/nvr_pulse_timer.sv
module nvr_pulse_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  assign last = run && nvr_pkg::pulse_last(int'(cnt_q), int'(len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nvr_verify_collect.sv
module nvr_verify_collect #(
  parameter int NDOM = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [NDOM-1:0] work,
  input  logic [NDOM-1:0] vfy_valid,
  input  logic [NDOM-1:0] vfy_pass,
  output logic            complete,
  output logic [NDOM-1:0] pass_mask
);
  logic [NDOM-1:0] got_q, ok_q, fresh;

  // first report of each selected domain is the one that counts
  assign fresh     = vfy_valid & work & ~got_q;
  assign complete  = active && (((got_q | fresh) & work) == work);
  assign pass_mask = (ok_q | (fresh & vfy_pass)) & work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q <= '0;
      ok_q  <= '0;
    end else if (!active) begin
      got_q <= '0;
      ok_q  <= '0;
    end else begin
      got_q <= got_q | fresh;
      ok_q  <= ok_q | (fresh & vfy_pass);
    end
  end

  // R4: recorded results never cover domains outside the working set
  assert_seen_in_work_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((got_q & ~work) == '0));
endmodule

// File: rtl/nvr_power_mgr.sv
module nvr_power_mgr #(
  parameter int NDOM = 10,
  parameter int PW   = 8,
  parameter int RW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [NDOM-1:0] cmd_mask,
  input  logic [PW-1:0]   store_len,
  input  logic [PW-1:0]   restore_len,
  input  logic [RW-1:0]   max_retry,
  output logic [NDOM-1:0] nv_store,
  output logic [NDOM-1:0] nv_restore,
  output logic [NDOM-1:0] nv_verify,
  input  logic [NDOM-1:0] vfy_valid,
  input  logic [NDOM-1:0] vfy_pass,
  output logic [NDOM-1:0] pwr_off,
  output logic [NDOM-1:0] iso,
  input  logic [NDOM-1:0] off_ack,
  input  logic [NDOM-1:0] pwr_good,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [NDOM-1:0] fail_mask
);
  import nvr_pkg::*;

  nvr_state_e      state_q;
  logic [NDOM-1:0] work_q, sleep_q, verified_q, iso_q, off_q, fail_q;
  logic [RW-1:0]   retries_q;
  logic            retry_en_q, then_sleep_q, wake_q, err_q, done_q;

  // named internal events
  logic            accept, p_run, p_last, v_active, v_complete, retry_ok;
  logic [PW-1:0]   p_len;
  logic [NDOM-1:0] unverified, v_pass, v_fail, sleep_keep;

  assign accept     = cmd_valid && (state_q == ST_IDLE);
  assign unverified = cmd_mask & ~verified_q;
  assign p_run      = (state_q == ST_STORE) || (state_q == ST_RST);
  assign p_len      = (state_q == ST_STORE) ? store_len : restore_len;
  assign v_active   = (state_q == ST_VFY);
  assign v_fail     = work_q & ~v_pass;
  assign sleep_keep = sleep_q & ~v_fail;
  assign retry_ok   = retry_en_q && retry_allowed(int'(retries_q), int'(max_retry));

  nvr_pulse_timer #(.CW(PW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .run(p_run), .len(p_len), .last(p_last)
  );

  nvr_verify_collect #(.NDOM(NDOM)) u_vfy (
    .clk(clk), .rst_n(rst_n), .active(v_active), .work(work_q),
    .vfy_valid(vfy_valid), .vfy_pass(vfy_pass),
    .complete(v_complete), .pass_mask(v_pass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      work_q       <= '0;
      sleep_q      <= '0;
      verified_q   <= '0;
      iso_q        <= '0;
      off_q        <= '0;
      fail_q       <= '0;
      retries_q    <= '0;
      retry_en_q   <= 1'b0;
      then_sleep_q <= 1'b0;
      wake_q       <= 1'b0;
      err_q        <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          retries_q    <= '0;
          work_q       <= cmd_mask;
          sleep_q      <= cmd_mask;
          retry_en_q   <= 1'b0;
          then_sleep_q <= 1'b0;
          wake_q       <= 1'b0;
          unique case (nvr_op_e'(cmd_op))
            OP_STORE:     state_q <= ST_STORE;
            OP_VERIFY:    state_q <= ST_VFY;
            OP_STORE_VFY: begin retry_en_q <= 1'b1; state_q <= ST_STORE; end
            OP_STORE_SLEEP: begin
              retry_en_q <= 1'b1; then_sleep_q <= 1'b1; state_q <= ST_STORE;
            end
            OP_SLEEP: if (unverified != '0) begin
              work_q <= unverified; retry_en_q <= 1'b1; then_sleep_q <= 1'b1;
              state_q <= ST_STORE;
            end else begin
              iso_q <= iso_q | cmd_mask; state_q <= ST_ISO;
            end
            OP_WAKE: begin
              off_q <= off_q & ~cmd_mask; wake_q <= 1'b1; state_q <= ST_PGW;
            end
            OP_RESTORE: state_q <= ST_RST;
            default:    done_q <= 1'b1;
          endcase
        end
        ST_STORE: begin
          verified_q <= verified_q & ~work_q;
          if (p_last) begin
            if (retry_en_q) state_q <= ST_VFY;
            else begin state_q <= ST_IDLE; done_q <= 1'b1; end
          end
        end
        ST_VFY: if (v_complete) begin
          verified_q <= (verified_q | v_pass) & ~v_fail;
          if (v_fail != '0 && retry_ok) begin
            retries_q <= retries_q + 1'b1;
            work_q    <= v_fail;
            state_q   <= ST_STORE;
          end else begin
            if (v_fail != '0) begin
              err_q  <= 1'b1;
              fail_q <= fail_q | v_fail;
            end
            if (then_sleep_q) begin
              sleep_q <= sleep_keep;
              iso_q   <= iso_q | sleep_keep;
              state_q <= ST_ISO;
            end else begin
              state_q <= ST_IDLE; done_q <= 1'b1;
            end
          end
        end
        ST_ISO: begin
          off_q   <= off_q | sleep_q;
          state_q <= ST_OFFW;
        end
        ST_OFFW: if ((off_ack & sleep_q) == sleep_q) begin
          state_q <= ST_IDLE; done_q <= 1'b1;
        end
        ST_PGW: if ((pwr_good & sleep_q) == sleep_q) state_q <= ST_RST;
        ST_RST: if (p_last) begin
          if (wake_q) iso_q <= iso_q & ~work_q;
          state_q <= ST_IDLE; done_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign fail_mask  = fail_q;
  assign iso        = iso_q;
  assign pwr_off    = off_q;
  assign nv_store   = (state_q == ST_STORE) ? work_q : '0;
  assign nv_restore = (state_q == ST_RST)   ? work_q : '0;
  assign nv_verify  = (state_q == ST_VFY)   ? work_q : '0;

  // R1: activity begins only from an accepted command
  assert_busy_from_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_ready));
  // R1: completion is a single-cycle pulse
  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: a rewrite bitmap never gains a domain
  assert_retry_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE && $past(state_q) == ST_VFY) |-> ((work_q & ~$past(work_q)) == '0));
  // R6: rewrites never exceed the programmed limit
  assert_retry_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (retries_q <= max_retry));
  // R7: clamp is in place the cycle before the switch opens
  assert_iso_leads_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_off & ~$past(pwr_off) & ~$past(iso)) == '0));
  // R7: an open switch is always clamped
  assert_off_needs_iso_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_off & ~iso) == '0));
endmodule

// File: tb/nvr_power_mgr_bench.sv
`timescale 1ns/1ps
module nvr_power_mgr_bench;
  localparam int ND = 10;
  localparam int NV = 12;
  localparam int VW = 43;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [ND-1:0] cmd_mask = '0;
  logic [7:0] store_len = 8'd3, restore_len = 8'd2;
  logic [3:0] max_retry = 4'd8;
  logic [ND-1:0] nv_store, nv_restore, nv_verify, vfy_valid, vfy_pass;
  logic [ND-1:0] pwr_off, iso, off_ack, pwr_good, fail_mask;
  logic busy, done, err;

  always #2 clk = ~clk;

  nvr_power_mgr u_nvr_power_mgr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mask(cmd_mask), .store_len(store_len),
    .restore_len(restore_len), .max_retry(max_retry), .nv_store(nv_store),
    .nv_restore(nv_restore), .nv_verify(nv_verify), .vfy_valid(vfy_valid),
    .vfy_pass(vfy_pass), .pwr_off(pwr_off), .iso(iso), .off_ack(off_ack),
    .pwr_good(pwr_good), .busy(busy), .done(done), .err(err), .fail_mask(fail_mask)
  );

  // domain model: verify answers after vdly cycles, switch answers after two
  int fails_left [ND];
  int vc [ND];
  int vdly = 1;
  logic [ND-1:0] o1 = '0, o2 = '0;
  assign off_ack  = o2;
  assign pwr_good = ~o2;

  always_comb begin
    for (int i = 0; i < ND; i++) begin
      vfy_valid[i] = nv_verify[i] && (vc[i] >= vdly);
      vfy_pass[i]  = (fails_left[i] == 0);
    end
  end

  always @(posedge clk) begin
    o1 <= pwr_off;
    o2 <= o1;
    for (int i = 0; i < ND; i++) begin
      if (nv_verify[i]) begin
        vc[i] <= vc[i] + 1;
        if (vfy_valid[i] && fails_left[i] > 0) fails_left[i] <= fails_left[i] - 1;
      end else vc[i] <= 0;
    end
  end

  // observers, sampled at the falling edge
  int scnt [ND];
  int st_cyc, rs_cyc, vf_cyc, done_cnt, busy_cyc, bad_ready, bad_order, bad_wake;
  logic in_wake = 1'b0;
  logic [ND-1:0] prev_store = '0, prev_iso = '0, prev_off = '0;

  always @(negedge clk) begin
    for (int i = 0; i < ND; i++)
      if (nv_store[i] && !prev_store[i]) scnt[i]++;
    if (nv_store != '0) st_cyc++;
    if (nv_restore != '0) rs_cyc++;
    if (nv_verify != '0) vf_cyc++;
    if (done) done_cnt++;
    if (busy) busy_cyc++;
    if (cmd_ready && busy) bad_ready++;
    if ((pwr_off & ~prev_off & ~prev_iso) != '0 || (pwr_off & ~iso) != '0) bad_order++;
    if (in_wake && ((nv_restore & ~pwr_good) != '0 || (nv_restore & ~iso) != '0)) bad_wake++;
    prev_store = nv_store;
    prev_iso   = iso;
    prev_off   = pwr_off;
  end

  int n_tests = 0, n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    for (int i = 0; i < ND; i++) scnt[i] = 0;
    st_cyc = 0; rs_cyc = 0; vf_cyc = 0; done_cnt = 0; busy_cyc = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    for (int i = 0; i < ND; i++) fails_left[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [ND-1:0] m);
    int t;
    @(negedge clk);
    clear_obs();
    in_wake  = (op == 3'd4);
    cmd_op   = op;
    cmd_mask = m;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (done_cnt == 0 && t < 3000) begin
      @(negedge clk); #1; t++;
    end
    check("R1 command completes", 32'(t < 3000), 32'd1);
    repeat (3) @(negedge clk);
    #1;
    check("R1 single done pulse", 32'(done_cnt), 32'd1);
    in_wake = 1'b0;
  endtask

  // {op, mask, verify-fail set, expected iso, expected pwr_off}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd2, 10'h003, 10'h002, 10'h000, 10'h000},
    {3'd3, 10'h00F, 10'h004, 10'h00F, 10'h00F},
    {3'd4, 10'h003, 10'h000, 10'h00C, 10'h00C},
    {3'd6, 10'h030, 10'h000, 10'h03C, 10'h03C},
    {3'd4, 10'h03C, 10'h000, 10'h000, 10'h000},
    {3'd0, 10'h100, 10'h000, 10'h000, 10'h000},
    {3'd3, 10'h100, 10'h100, 10'h100, 10'h100},
    {3'd4, 10'h100, 10'h000, 10'h000, 10'h000},
    {3'd5, 10'h3FF, 10'h000, 10'h000, 10'h000},
    {3'd1, 10'h200, 10'h000, 10'h000, 10'h000},
    {3'd3, 10'h200, 10'h200, 10'h200, 10'h200},
    {3'd4, 10'h200, 10'h000, 10'h000, 10'h000}
  };

  initial begin : watchdog
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [ND-1:0] vm, unv;
    logic [2:0] op;
    logic [ND-1:0] m, fs;
    int exp_cnt, bad;

    clear_obs();
    bad_ready = 0; bad_order = 0; bad_wake = 0;
    for (int i = 0; i < ND; i++) begin fails_left[i] = 0; vc[i] = 0; end
    do_reset();

    // R12 reset state
    check("R12 cmd_ready after reset", 32'(cmd_ready), 32'd1);
    check("R12 busy after reset", 32'(busy), 32'd0);
    check("R12 iso/pwr_off after reset", {12'd0, iso, pwr_off}, 32'd0);
    check("R12 err/fail_mask after reset", {21'd0, err, fail_mask}, 32'd0);
    check("R12 pulses idle after reset", {2'd0, nv_store, nv_restore, nv_verify}, 32'd0);

    // table walk: R5 R7 R8 R9 R10 R11
    vm = '0;
    for (int k = 0; k < NV; k++) begin
      op = VEC[k][42:40];
      m  = VEC[k][39:30];
      fs = VEC[k][29:20];
      for (int i = 0; i < ND; i++) fails_left[i] = fs[i] ? 1 : 0;
      run_cmd(op, m);
      bad = 0;
      unv = m & ~vm;
      for (int i = 0; i < ND; i++) begin
        exp_cnt = 0;
        if (op == 3'd0) exp_cnt = m[i] ? 1 : 0;
        else if (op == 3'd2 || op == 3'd6) exp_cnt = m[i] ? (fs[i] ? 2 : 1) : 0;
        else if (op == 3'd3) exp_cnt = unv[i] ? (fs[i] ? 2 : 1) : 0;
        if (scnt[i] != exp_cnt) bad++;
      end
      if (op == 3'd0) vm = vm & ~m;
      else if (op == 3'd1 || op == 3'd2 || op == 3'd3 || op == 3'd6) vm = vm | m;
      check($sformatf("R5 R9 R11 write pulses per domain vec %0d", k), 32'(bad), 32'd0);
      check($sformatf("R7 R8 R10 iso vec %0d", k), 32'(iso), 32'(VEC[k][19:10]));
      check($sformatf("R7 R8 R10 pwr_off vec %0d", k), 32'(pwr_off), 32'(VEC[k][9:0]));
      check($sformatf("R6 no error vec %0d", k), 32'(err), 32'd0);
    end
    check("R1 ready never with busy", 32'(bad_ready), 32'd0);
    check("R7 isolation ordering", 32'(bad_order), 32'd0);
    check("R8 readback after power good under clamp", 32'(bad_wake), 32'd0);

    // R2 pulse widths
    store_len = 8'd5;
    run_cmd(3'd0, 10'h001);
    check("R2 write pulse 5 cycles", 32'(st_cyc), 32'd5);
    check("R1 busy seen during command", 32'(busy_cyc > 0), 32'd1);
    store_len = 8'd0;
    run_cmd(3'd0, 10'h001);
    check("R2 write pulse zero length acts as one", 32'(st_cyc), 32'd1);
    store_len = 8'd3;

    // R3 read-back width
    restore_len = 8'd4;
    run_cmd(3'd5, 10'h002);
    check("R3 readback pulse 4 cycles", 32'(rs_cyc), 32'd4);
    restore_len = 8'd2;

    // R4 verify waits for valid
    vdly = 6;
    run_cmd(3'd1, 10'h001);
    check("R4 verify held until valid", 32'(vf_cyc), 32'd7);
    vdly = 1;

    // R1 no-operation code
    run_cmd(3'd7, 10'h3FF);
    check("R1 no-op leaves controls", {12'd0, iso, pwr_off}, 32'd0);

    // R6 R7 retry exhaustion keeps failed domain powered
    do_reset();
    max_retry = 4'd2;
    fails_left[0] = 100;
    run_cmd(3'd6, 10'h003);
    check("R6 err set on exhaustion", 32'(err), 32'd1);
    check("R6 fail_mask records domain", 32'(fail_mask), 32'h001);
    check("R6 write count 1 plus limit", 32'(scnt[0]), 32'd3);
    check("R5 passing domain written once", 32'(scnt[1]), 32'd1);
    check("R7 failed domain not powered down", {12'd0, iso, pwr_off}, {12'd0, 10'h002, 10'h002});

    // R6 sticky
    fails_left[0] = 0;
    run_cmd(3'd2, 10'h004);
    check("R6 err sticky", {21'd0, err, fail_mask}, {21'd0, 1'b1, 10'h001});

    // R6 zero retry limit
    do_reset();
    max_retry = 4'd0;
    fails_left[5] = 1;
    run_cmd(3'd2, 10'h020);
    check("R6 zero limit no rewrite", 32'(scnt[5]), 32'd1);
    check("R6 zero limit error", {21'd0, err, fail_mask}, {21'd0, 1'b1, 10'h020});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule